// File: doc/BRIEF.md
# DMA Channel Address Register Unit

This unit keeps the two address pointers of one DMA channel: a source pointer that is placed on the address bus while an operand is being fetched, and a destination pointer that is placed on the bus while that operand is being stored. When a phase completes, the matching pointer advances by the operand width, but only if that pointer's own increment enable is set. Software loads and inspects both pointers through a small register bus. A readback always returns the address that the next transfer will use.

Before a transfer starts, the unit checks operand alignment. A word or long-word operand whose source or destination address is odd raises a sticky configuration error, and no phase is started. The error also blocks every later request until software clears it. Arbitration, channel sequencing beyond one fetch/store pair, byte counting and interrupts belong to the surrounding channel logic. That logic drives the request, the done strobes and the bus-error strobe.

Top module: `dma_addr_unit`

## Requirements
- R1: On completion of a phase whose pointer has its increment enable set, that pointer advances by 1, 2 or 4 for operand size code 00 (byte), 01 (word) or 10 (long word).
- R2: Pointer arithmetic is unsigned modulo 2^32, so stepping past FFFFFFFF wraps to a small value (FFFFFFFC + 4 gives 0, FFFFFFFF + 1 gives 0).
- R3: A pointer whose increment enable is clear keeps its value across its phase.
- R4: A request made with size code 11, or with a word or long-word size while bit 0 of either pointer is 1, sets cfg_err in the next cycle and starts no phase. A byte request is accepted at any address.
- R5: cfg_err stays set until a register write to offset 2 with data bit 0 equal to 1. A write there with bit 0 equal to 0 leaves it set. While it is set, requests start no phase.
- R6: An accepted request opens the read phase on the next cycle, with the source pointer on bus_addr. rd_done opens the write phase, with the destination pointer on bus_addr. wr_done returns the unit to idle. bus_addr_vld is high only in a phase, and bus_addr is 0 when idle.
- R7: The register bus decodes offset 0 as the source pointer, offset 1 as the destination pointer and offset 2 as status (bit 0 is cfg_err). rb_rdata is combinational, and a write or step becomes visible in the cycle after its clock edge.
- R8: A bus error reported with rd_done ends the transfer without a write phase, and the source pointer still advances. A bus error reported with wr_done still advances the destination pointer.
- R9: Register writes, including the status clear, have no effect while stop is 1.
- R10: Reset clears the phase and cfg_err but leaves both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop | input | 1 | Module stopped; register writes are ignored |
| rb_wr | input | 1 | Register bus write strobe |
| rb_addr | input | 2 | Register bus offset |
| rb_wdata | input | 32 | Register bus write data |
| rb_rdata | output | 32 | Register bus read data for rb_addr |
| op_size | input | 2 | Operand size code |
| src_inc_en | input | 1 | Source pointer increment enable |
| dst_inc_en | input | 1 | Destination pointer increment enable |
| xfer_req | input | 1 | Request to start one fetch/store transfer |
| rd_done | input | 1 | Read phase finished |
| wr_done | input | 1 | Write phase finished |
| bus_err | input | 1 | The finishing phase ended with a bus error |
| bus_addr | output | 32 | Address presented to the bus |
| bus_addr_vld | output | 1 | bus_addr is valid |
| rd_phase | output | 1 | Read phase in progress |
| wr_phase | output | 1 | Write phase in progress |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
Every result of this unit is due exactly one clock edge after its cause. The read phase appears one edge after the request edge. The write phase and the stepped source pointer appear one edge after rd_done. The stepped destination pointer and the return to idle appear one edge after wr_done. cfg_err appears one edge after a misaligned request. The bench drives each stimulus two nanoseconds after a rising edge, advances exactly one edge, and samples two nanoseconds later. This keeps every expected value tied to a single registered update. Readbacks are taken combinationally in the following idle cycle.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  typedef enum logic [1:0] {
    OPSZ_BYTE = 2'b00,
    OPSZ_WORD = 2'b01,
    OPSZ_LONG = 2'b10,
    OPSZ_RSVD = 2'b11
  } opsz_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_READ  = 2'b01,
    PH_WRITE = 2'b10
  } phase_e;

  localparam int unsigned RB_AW = 2;
  localparam logic [RB_AW-1:0] RB_SRC  = 2'd0;
  localparam logic [RB_AW-1:0] RB_DST  = 2'd1;
  localparam logic [RB_AW-1:0] RB_STAT = 2'd2;

  // Byte distance covered by one operand of the given size.
  function automatic logic [2:0] step_of(opsz_e sz);
    case (sz)
      OPSZ_WORD: step_of = 3'd2;
      OPSZ_LONG: step_of = 3'd4;
      default:   step_of = 3'd1;
    endcase
  endfunction

  function automatic logic size_legal(opsz_e sz);
    size_legal = (sz != OPSZ_RSVD);
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_data,
  input  logic          step_en,
  input  logic [SW-1:0] step_amt,
  output logic [AW-1:0] q
);

  logic [AW-1:0] d;
  logic          en;

  // A software load takes priority over a step in the same cycle.
  always_comb begin
    en = sw_wr | step_en;
    if (sw_wr) d = sw_data;
    else       d = q + AW'(step_amt);
  end

  // The pointer has no reset: its contents survive a reset.
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_addr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ns,
  input  logic   xfer_req,
  input  logic   rd_done,
  input  logic   wr_done,
  input  logic   bus_err,
  input  logic   misaligned,
  input  logic   err_clr,
  output phase_e phase,
  output logic   cfg_err,
  output logic   src_end,
  output logic   dst_end
);

  phase_e phase_d;
  logic   err_d;

  always_comb begin
    phase_d = phase;
    err_d   = cfg_err;
    src_end = 1'b0;
    dst_end = 1'b0;
    if (err_clr) err_d = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (xfer_req && !cfg_err) begin
          if (misaligned) err_d   = 1'b1;
          else            phase_d = PH_READ;
        end
      end
      PH_READ: begin
        if (rd_done) begin
          src_end = 1'b1;
          phase_d = bus_err ? PH_IDLE : PH_WRITE;
        end
      end
      PH_WRITE: begin
        if (wr_done) begin
          dst_end = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase   <= PH_IDLE;
      cfg_err <= 1'b0;
    end else begin
      phase   <= phase_d;
      cfg_err <= err_d;
    end
  end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_addr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop,
  input  logic          rb_wr,
  input  logic [1:0]    rb_addr,
  input  logic [AW-1:0] rb_wdata,
  output logic [AW-1:0] rb_rdata,
  input  logic [1:0]    op_size,
  input  logic          src_inc_en,
  input  logic          dst_inc_en,
  input  logic          xfer_req,
  input  logic          rd_done,
  input  logic          wr_done,
  input  logic          bus_err,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_vld,
  output logic          rd_phase,
  output logic          wr_phase,
  output logic          cfg_err
);

  localparam int unsigned NREG = 2;
  localparam int unsigned SW   = 3;

  logic            rst_ns;
  logic [AW-1:0]   addr_q [NREG];
  logic [NREG-1:0] sw_wr;
  logic [NREG-1:0] inc_en;
  logic [NREG-1:0] phase_end;
  logic [NREG-1:0] step_en;
  logic [SW-1:0]   step_amt;
  logic            sw_ok;
  logic            misaligned;
  logic            err_clr;
  opsz_e           size;
  phase_e          phase;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign size     = opsz_e'(op_size);
  assign sw_ok    = rb_wr & ~stop;
  assign sw_wr[0] = sw_ok & (rb_addr == RB_SRC);
  assign sw_wr[1] = sw_ok & (rb_addr == RB_DST);
  assign err_clr  = sw_ok & (rb_addr == RB_STAT) & rb_wdata[0];
  assign inc_en   = {dst_inc_en, src_inc_en};
  assign step_amt = step_of(size);

  always_comb begin
    misaligned = !size_legal(size) ||
                 ((size != OPSZ_BYTE) && (addr_q[0][0] || addr_q[1][0]));
  end

  dma_xfer_seq u_seq (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .xfer_req   (xfer_req),
    .rd_done    (rd_done),
    .wr_done    (wr_done),
    .bus_err    (bus_err),
    .misaligned (misaligned),
    .err_clr    (err_clr),
    .phase      (phase),
    .cfg_err    (cfg_err),
    .src_end    (phase_end[0]),
    .dst_end    (phase_end[1])
  );

  for (genvar g = 0; g < NREG; g++) begin : g_ptr
    assign step_en[g] = phase_end[g] & inc_en[g];
    dma_addr_reg #(.AW(AW), .SW(SW)) u_reg (
      .clk      (clk),
      .sw_wr    (sw_wr[g]),
      .sw_data  (rb_wdata),
      .step_en  (step_en[g]),
      .step_amt (step_amt),
      .q        (addr_q[g])
    );
  end

  always_comb begin
    rd_phase     = (phase == PH_READ);
    wr_phase     = (phase == PH_WRITE);
    bus_addr_vld = rd_phase | wr_phase;
    if (rd_phase)      bus_addr = addr_q[0];
    else if (wr_phase) bus_addr = addr_q[1];
    else               bus_addr = '0;
  end

  always_comb begin
    case (rb_addr)
      RB_SRC:  rb_rdata = addr_q[0];
      RB_DST:  rb_rdata = addr_q[1];
      RB_STAT: rb_rdata = {{(AW-1){1'b0}}, cfg_err};
      default: rb_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_addr_unit_chk.sv
module dma_addr_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          stop,
  input logic          rb_wr,
  input logic [1:0]    rb_addr,
  input logic [1:0]    op_size,
  input logic          src_inc_en,
  input logic          xfer_req,
  input logic          rd_done,
  input logic          bus_err,
  input logic          rd_phase,
  input logic          wr_phase,
  input logic          bus_addr_vld,
  input logic          cfg_err,
  input logic [AW-1:0] bus_addr,
  input logic [AW-1:0] sar_q,
  input logic [AW-1:0] dar_q
);

  logic src_load;
  assign src_load = rb_wr && !stop && (rb_addr == 2'd0);

  // R1
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_phase && rd_done && src_inc_en && !src_load
    |=> sar_q == $past(sar_q) + (AW'(1) << $past(op_size)));

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_phase && rd_done && !src_inc_en && !src_load |=> $stable(sar_q));

  // R4
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_phase && !wr_phase && xfer_req && !cfg_err && op_size != 2'd0 && sar_q[0]
    |=> cfg_err && !rd_phase);

  // R5
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cfg_err && !rd_phase && !wr_phase |=> !rd_phase);

  // R6
  phase_one_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({rd_phase, wr_phase}) && (bus_addr_vld == (rd_phase || wr_phase)));

  // R6
  src_drive_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_phase |-> bus_addr == sar_q);

  // R6
  dst_drive_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_phase |-> bus_addr == dar_q);

  // R8
  rd_berr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_phase && rd_done && bus_err |=> !wr_phase && !rd_phase);

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    stop && !rd_phase && !wr_phase |=> $stable(sar_q) && $stable(dar_q));

endmodule

bind dma_addr_unit dma_addr_unit_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_ns       (rst_ns),
  .stop         (stop),
  .rb_wr        (rb_wr),
  .rb_addr      (rb_addr),
  .op_size      (op_size),
  .src_inc_en   (src_inc_en),
  .xfer_req     (xfer_req),
  .rd_done      (rd_done),
  .bus_err      (bus_err),
  .rd_phase     (rd_phase),
  .wr_phase     (wr_phase),
  .bus_addr_vld (bus_addr_vld),
  .cfg_err      (cfg_err),
  .bus_addr     (bus_addr),
  .sar_q        (addr_q[0]),
  .dar_q        (addr_q[1])
);

// File: tb/tb_dma_addr_unit.sv
`timescale 1ns/1ps
module tb_dma_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stop;
  logic        rb_wr;
  logic [1:0]  rb_addr;
  logic [31:0] rb_wdata;
  logic [31:0] rb_rdata;
  logic [1:0]  op_size;
  logic        src_inc_en, dst_inc_en;
  logic        xfer_req, rd_done, wr_done, bus_err;
  logic [31:0] bus_addr;
  logic        bus_addr_vld, rd_phase, wr_phase, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .stop(stop), .rb_wr(rb_wr), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .op_size(op_size),
    .src_inc_en(src_inc_en), .dst_inc_en(dst_inc_en), .xfer_req(xfer_req),
    .rd_done(rd_done), .wr_done(wr_done), .bus_err(bus_err),
    .bus_addr(bus_addr), .bus_addr_vld(bus_addr_vld), .rd_phase(rd_phase),
    .wr_phase(wr_phase), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic        sinc;
    logic        dinc;
    logic        berr;
    logic        err;
    logic [31:0] sar;
    logic [31:0] dar;
    logic [31:0] esar;
    logic [31:0] edar;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'h0000_1001, 32'h0000_2001},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_2002, 32'h0000_1002, 32'h0000_2004},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 32'h0000_0010, 32'h0000_0000, 32'h0000_0014},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_3000, 32'h0000_4000, 32'h0000_3000, 32'h0000_4004},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_6000, 32'h0000_5002, 32'h0000_6000},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_1001, 32'h0000_2000, 32'h0000_1001, 32'h0000_2000},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0100, 32'h0000_0203, 32'h0000_0100, 32'h0000_0203},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1003, 32'h0000_2005, 32'h0000_1004, 32'h0000_2006},
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0800, 32'h0000_0900, 32'h0000_0804, 32'h0000_0900},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rb_write(logic [1:0] a, logic [31:0] d);
    rb_wr = 1'b1; rb_addr = a; rb_wdata = d;
    step();
    rb_wr = 1'b0;
  endtask

  task automatic rb_read(logic [1:0] a, logic [31:0] exp, string tag);
    rb_addr = a;
    #1;
    chk(tag, rb_rdata, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; stop = 1'b0; rb_wr = 1'b0; rb_addr = 2'd0; rb_wdata = '0;
    op_size = 2'd0; src_inc_en = 1'b0; dst_inc_en = 1'b0;
    xfer_req = 1'b0; rd_done = 1'b0; wr_done = 1'b0; bus_err = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R10 R6: state after reset
    chk("R10 cfg_err after reset", {31'd0, cfg_err}, 32'd0);
    chk("R6 vld idle after reset", {31'd0, bus_addr_vld}, 32'd0);
    chk("R6 bus_addr idle after reset", bus_addr, 32'd0);
    rb_read(2'd2, 32'd0, "R7 status after reset");

    // Vector table walk: R1 R2 R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      rb_write(2'd0, VECS[i].sar);
      rb_write(2'd1, VECS[i].dar);
      rb_write(2'd2, 32'd1);
      op_size = VECS[i].size; src_inc_en = VECS[i].sinc; dst_inc_en = VECS[i].dinc;
      xfer_req = 1'b1;
      step();
      xfer_req = 1'b0;
      if (VECS[i].err) begin
        chk("R4 cfg_err on misaligned", {31'd0, cfg_err}, 32'd1);
        chk("R4 no read phase", {31'd0, rd_phase}, 32'd0);
      end else begin
        chk("R4 byte or aligned accepted", {31'd0, cfg_err}, 32'd0);
        chk("R6 read phase open", {31'd0, rd_phase}, 32'd1);
        chk("R6 source on bus", bus_addr, VECS[i].sar);
        chk("R6 vld in read", {31'd0, bus_addr_vld}, 32'd1);
        rd_done = 1'b1; bus_err = VECS[i].berr;
        step();
        rd_done = 1'b0; bus_err = 1'b0;
        if (VECS[i].berr) begin
          chk("R8 no write phase after bus error", {30'd0, wr_phase, rd_phase}, 32'd0);
        end else begin
          chk("R6 write phase open", {31'd0, wr_phase}, 32'd1);
          chk("R6 destination on bus", bus_addr, VECS[i].dar);
          wr_done = 1'b1;
          step();
          wr_done = 1'b0;
          chk("R6 vld low when idle", {31'd0, bus_addr_vld}, 32'd0);
        end
      end
      rb_read(2'd0, VECS[i].esar, "R1 R2 R3 R7 R8 source readback");
      rb_read(2'd1, VECS[i].edar, "R1 R2 R3 R7 destination readback");
      rb_read(2'd2, {31'd0, VECS[i].err}, "R4 R7 status readback");
    end

    // R5: sticky error blocks requests; only a one clears it
    rb_write(2'd2, 32'd1);
    op_size = 2'd1;
    rb_write(2'd0, 32'h0000_7001);
    rb_write(2'd1, 32'h0000_8000);
    xfer_req = 1'b1; step(); xfer_req = 1'b0;
    chk("R4 error raised", {31'd0, cfg_err}, 32'd1);
    rb_write(2'd0, 32'h0000_7000);
    xfer_req = 1'b1; step(); xfer_req = 1'b0;
    chk("R5 request blocked while error", {31'd0, rd_phase}, 32'd0);
    rb_write(2'd2, 32'd0);
    chk("R5 write of zero keeps error", {31'd0, cfg_err}, 32'd1);
    stop = 1'b1;
    rb_write(2'd2, 32'd1);
    chk("R9 clear ignored when stopped", {31'd0, cfg_err}, 32'd1);
    stop = 1'b0;
    rb_write(2'd2, 32'd1);
    chk("R5 write of one clears error", {31'd0, cfg_err}, 32'd0);
    xfer_req = 1'b1; step(); xfer_req = 1'b0;
    chk("R5 request accepted after clear", {31'd0, rd_phase}, 32'd1);
    rd_done = 1'b1; step(); rd_done = 1'b0;
    wr_done = 1'b1; bus_err = 1'b1; step(); wr_done = 1'b0; bus_err = 1'b0;
    rb_read(2'd1, 32'h0000_8002, "R8 destination advances on write bus error");

    // R9: pointer writes ignored while stopped
    rb_write(2'd0, 32'hA5A5_0000);
    rb_write(2'd1, 32'h5A5A_0000);
    stop = 1'b1;
    rb_write(2'd0, 32'h1234_5678);
    rb_write(2'd1, 32'h8765_4321);
    stop = 1'b0;
    rb_read(2'd0, 32'hA5A5_0000, "R9 source unchanged while stopped");
    rb_read(2'd1, 32'h5A5A_0000, "R9 destination unchanged while stopped");

    // R10: reset leaves pointers alone, clears error
    rb_write(2'd0, 32'hCAFE_0004);
    rb_write(2'd1, 32'hBEEF_0008);
    op_size = 2'd3;
    xfer_req = 1'b1; step(); xfer_req = 1'b0;
    chk("R4 reserved size raises error", {31'd0, cfg_err}, 32'd1);
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    rb_read(2'd0, 32'hCAFE_0004, "R10 source kept over reset");
    rb_read(2'd1, 32'hBEEF_0008, "R10 destination kept over reset");
    chk("R10 error cleared by reset", {31'd0, cfg_err}, 32'd0);

    summary();
  end

endmodule